// File: doc/BRIEF.md
# Buffered 16-bit Timer/Counter

This block is a 16-bit up-counter reached through an 8-bit register interface. It either counts an internal tick that occurs once every four system clocks, or counts rising edges on an external input. External edges take one of two paths. The first path passes the edges through a synchronizer and edge detector, so each edge is re-timed to the system clock. The second path detects each edge directly, without re-timing, and it keeps working while the device sleeps.

A 2-bit field selects a prescale ratio of 1, 2, 4 or 8, applied ahead of the counter. An enable bit gates counting. A wrap from all-ones to zero sets a sticky overflow flag, which also drives an interrupt output. A clear input from a compare unit forces the count to zero.

A wide-access mode reaches the upper byte through a holding buffer, so that software can read or write the full count atomically with two byte accesses. In that mode the lower byte is always accessed second when writing and first when reading.

Top module: `evt_timer16`

## Requirements
- R1: After reset the control register (address 0), count low byte (address 1) and count high byte (address 2) all read 0x00, and irq_o is low. Address 3 always reads 0x00.
- R2: Control bit 1 (source select) = 0 selects timer mode. With the prescaler at divide-by-1 and counting enabled, the count advances once every 4 system clock cycles.
- R3: Control bits [4:3] select the prescale ratio 2^n (1, 2, 4 or 8) applied to the chosen source.
- R4: With control bit 1 = 1 and control bit 2 = 0, each rising edge of ext_i is counted once. The count changes on the third rising clock edge after ext_i goes high.
- R5: With control bits 1 and 2 both set, a rising ext_i edge is counted on the first rising clock edge at which ext_i is high, having been low on the previous clock edge.
- R6: While control bit 0 (enable) is 0, the count holds its value, unless a byte write or a compare clear changes it.
- R7: When the count advances from 0xFFFF, it becomes 0x0000 and the overflow flag (control bit 6, also irq_o) is set. The flag then stays set until the control register is written with bit 6 = 0; writing a 1 to bit 6 has no effect.
- R8: A high level on clr_i at a clock edge sets the count to 0x0000. A count-byte write in the same cycle takes priority over the clear.
- R9: While sleep_i is high, the internal tick and the synchronized external path produce no counts. The unsynchronized external path keeps counting.
- R10: With control bit 5 (wide mode) = 0, a write to address 1 or 2 changes only that byte of the live count, and a read of address 2 returns the live high byte.
- R11: With wide mode on, a read of address 1 copies the live high byte into the holding buffer, and a read of address 2 returns that buffer. A write to address 2 loads only the buffer. A write to address 1 loads the count with {buffer, written byte}.
- R12: Any write to address 1 or 2 restarts the prescaler, so the next count needs a full ratio of source events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Device sleep indication |
| ext_i | input | 1 | External count input |
| clr_i | input | 1 | Count clear from compare unit |
| addr_i | input | 2 | Register address |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (side effect in wide mode) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| irq_o | output | 1 | Overflow flag |

## Verification
Read data is combinational from the address, so the bench drives the address half a period away from the clock edge and compares the result within the same cycle. Writes, clears and results from the unsynchronized path take effect on the first clock edge after they are applied. A synchronized external edge shows up only after the third edge. The bench samples that case at each of the three edges, to confirm the count does not change before it is due. Timer and prescaler tests set the enable bit for an exact number of clock edges, chosen as a multiple of 4 times the ratio. Because the prescaler starts cleared, the resulting count is exact whatever phase the tick divider happens to be in.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LO   = 2'd1,
    REG_HI   = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       spare;
    logic       ovf;
    logic       wide;
    logic [1:0] psel;
    logic       unsync;
    logic       ext_sel;
    logic       run_en;
  } ctrl_t;
endpackage

// File: rtl/evt_timer_src.sv
module evt_timer_src #(
  parameter int unsigned TICK_DIV = 4,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  input  logic ext_i,
  input  logic run_en_i,
  input  logic ext_sel_i,
  input  logic unsync_i,
  output logic pulse_o
);
  localparam int unsigned TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned SW = SYNC_LEN + 1;

  logic [TW-1:0] ph_q;
  logic [SW-1:0] sy_q;
  logic          as_q;
  logic          tick, sync_edge, as_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ph_q <= '0;
    else if (ph_q == TW'(TICK_DIV - 1))  ph_q <= '0;
    else                                 ph_q <= ph_q + 1'b1;
  end

  // synchronizer chain plus one edge-detect stage, held idle in sleep
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sy_q <= '0;
    else if (sleep_i) sy_q <= '0;
    else              sy_q <= {sy_q[SW-2:0], ext_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) as_q <= 1'b0;
    else         as_q <= ext_i;
  end

  assign tick      = (ph_q == TW'(TICK_DIV - 1)) && !sleep_i;
  assign sync_edge = sy_q[SW-2] & ~sy_q[SW-1];
  assign as_edge   = ext_i & ~as_q;

  always_comb begin
    if (!run_en_i)      pulse_o = 1'b0;
    else if (!ext_sel_i) pulse_o = tick;
    else if (unsync_i)  pulse_o = as_edge;
    else                pulse_o = sync_edge;
  end
endmodule

// File: rtl/evt_timer_presc.sv
module evt_timer_presc #(
  parameter int unsigned PS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [PS_W-1:0] psel_i,
  input  logic            pulse_i,
  output logic            inc_o
);
  localparam int unsigned DW = (1 << PS_W) - 1;

  logic [DW-1:0] div_q;
  logic [DW-1:0] mask;

  assign mask  = ~({DW{1'b1}} << psel_i);
  assign inc_o = pulse_i && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (clr_i)   div_q <= '0;
    else if (pulse_i) div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic              rd_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_i,
  input  logic              inc_i,
  input  logic              flag_clr_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] hi_buf_o,
  output logic              flag_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] buf_q;
  logic              flag_q;
  logic              hi_live_wr, any_wr, wrap;

  assign hi_live_wr = wr_hi_i && !wide_i;
  assign any_wr     = wr_lo_i || hi_live_wr;
  assign wrap       = inc_i && (cnt_q == {CNT_W{1'b1}}) && !any_wr && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (wr_lo_i)    cnt_q <= wide_i ? {buf_q, wdata_i} : {cnt_q[CNT_W-1:DATA_W], wdata_i};
    else if (hi_live_wr) cnt_q <= {wdata_i, cnt_q[DATA_W-1:0]};
    else if (clr_i)      cnt_q <= '0;
    else if (inc_i)      cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  buf_q <= '0;
    else if (wide_i && wr_hi_i)   buf_q <= wdata_i;
    else if (wide_i && rd_lo_i)   buf_q <= cnt_q[CNT_W-1:DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (wrap)       flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign cnt_o    = cnt_q;
  assign hi_buf_o = buf_q;
  assign flag_o   = flag_q;
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
  import evt_timer_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned TICK_DIV = 4,
  parameter int unsigned SYNC_LEN = 2,
  localparam int unsigned CNT_W   = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              ext_i,
  input  logic              clr_i,
  input  logic [1:0]        addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t             wctrl, rctrl;
  logic              run_en_q, ext_sel_q, unsync_q, wide_q, spare_q;
  logic [1:0]        psel_q;
  logic              wr_ctrl, wr_lo, wr_hi, rd_lo, flag_clr;
  logic              src_pulse, inc;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] hi_buf;
  logic              flag;

  assign wctrl    = ctrl_t'(wdata_i[7:0]);
  assign wr_ctrl  = we_i && (addr_i == REG_CTRL);
  assign wr_lo    = we_i && (addr_i == REG_LO);
  assign wr_hi    = we_i && (addr_i == REG_HI);
  assign rd_lo    = re_i && (addr_i == REG_LO);
  assign flag_clr = wr_ctrl && !wctrl.ovf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_en_q  <= 1'b0;
      ext_sel_q <= 1'b0;
      unsync_q  <= 1'b0;
      psel_q    <= '0;
      wide_q    <= 1'b0;
      spare_q   <= 1'b0;
    end else if (wr_ctrl) begin
      run_en_q  <= wctrl.run_en;
      ext_sel_q <= wctrl.ext_sel;
      unsync_q  <= wctrl.unsync;
      psel_q    <= wctrl.psel;
      wide_q    <= wctrl.wide;
      spare_q   <= wctrl.spare;
    end
  end

  evt_timer_src #(.TICK_DIV(TICK_DIV), .SYNC_LEN(SYNC_LEN)) u_src (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sleep_i   (sleep_i),
    .ext_i     (ext_i),
    .run_en_i  (run_en_q),
    .ext_sel_i (ext_sel_q),
    .unsync_i  (unsync_q),
    .pulse_o   (src_pulse)
  );

  evt_timer_presc #(.PS_W(2)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (wr_lo || wr_hi),
    .psel_i  (psel_q),
    .pulse_i (src_pulse),
    .inc_o   (inc)
  );

  evt_timer_core #(.DATA_W(DATA_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wide_i     (wide_q),
    .wr_lo_i    (wr_lo),
    .wr_hi_i    (wr_hi),
    .rd_lo_i    (rd_lo),
    .wdata_i    (wdata_i),
    .clr_i      (clr_i),
    .inc_i      (inc),
    .flag_clr_i (flag_clr),
    .cnt_o      (cnt),
    .hi_buf_o   (hi_buf),
    .flag_o     (flag)
  );

  always_comb begin
    rctrl = '{spare: spare_q, ovf: flag, wide: wide_q, psel: psel_q,
              unsync: unsync_q, ext_sel: ext_sel_q, run_en: run_en_q};
    rdata_o = '0;
    unique case (addr_i)
      REG_CTRL: rdata_o[7:0] = rctrl;
      REG_LO:   rdata_o      = cnt[DATA_W-1:0];
      REG_HI:   rdata_o      = wide_q ? hi_buf : cnt[CNT_W-1:DATA_W];
      default:  rdata_o      = '0;
    endcase
  end

  assign irq_o = flag;
endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sleep_i,
  input logic              clr_i,
  input logic              run_en,
  input logic              ext_sel,
  input logic              unsync,
  input logic              wide,
  input logic              wr_lo,
  input logic              wr_hi,
  input logic              rd_lo,
  input logic              flag_clr,
  input logic              src_pulse,
  input logic              inc,
  input logic [CNT_W-1:0]  cnt,
  input logic [DATA_W-1:0] hi_buf,
  input logic              flag
);
  assert_hold_when_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_en && !wr_lo && !wr_hi && !clr_i) |=> $stable(cnt));

  assert_wrap_sets_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc && cnt == {CNT_W{1'b1}} && !wr_lo && !wr_hi && !clr_i) |=> (flag && cnt == '0));

  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && !flag_clr) |=> flag);

  assert_clear_zeroes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !wr_lo && !(wr_hi && !wide)) |=> cnt == '0);

  assert_sleep_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && !(ext_sel && unsync)) |-> !src_pulse);

  assert_inc_needs_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc |-> src_pulse);

  assert_buf_capture_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide && rd_lo && !wr_hi) |=> hi_buf == $past(cnt[CNT_W-1:DATA_W]));
endmodule

bind evt_timer16 evt_timer16_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sleep_i   (sleep_i),
  .clr_i     (clr_i),
  .run_en    (run_en_q),
  .ext_sel   (ext_sel_q),
  .unsync    (unsync_q),
  .wide      (wide_q),
  .wr_lo     (wr_lo),
  .wr_hi     (wr_hi),
  .rd_lo     (rd_lo),
  .flag_clr  (flag_clr),
  .src_pulse (src_pulse),
  .inc       (inc),
  .cnt       (cnt),
  .hi_buf    (hi_buf),
  .flag      (flag)
);

// File: tb/evt_timer16_bench.sv
module evt_timer16_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep = 1'b0;
  logic       ext = 1'b0;
  logic       clr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       we = 1'b0;
  logic       re = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  evt_timer16 u_evt_timer16 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .sleep_i (sleep),
    .ext_i   (ext),
    .clr_i   (clr),
    .addr_i  (addr),
    .we_i    (we),
    .re_i    (re),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  localparam logic [7:0] C_OFF    = 8'h40;
  localparam logic [7:0] C_TMR1   = 8'h41;
  localparam logic [7:0] C_TMR2   = 8'h49;
  localparam logic [7:0] C_TMR8   = 8'h59;
  localparam logic [7:0] C_SYNC   = 8'h43;
  localparam logic [7:0] C_ASYNC  = 8'h47;
  localparam logic [7:0] C_AS2    = 8'h4F;
  localparam logic [7:0] C_AS4    = 8'h57;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, string req, logic [7:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic rd_lo(string req, logic [7:0] exp);
    addr = 2'd1; re = 1'b1;
    #1;
    check(req, rdata, exp);
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic set_cnt(logic [15:0] v);
    wr(2'd1, v[7:0]);
    wr(2'd2, v[15:8]);
  endtask

  task automatic pulse();
    ext = 1'b1; idle(3);
    ext = 1'b0; idle(3);
  endtask

  task automatic t_reset();
    peek(2'd0, "R1 ctrl", 8'h00);
    peek(2'd1, "R1 lo", 8'h00);
    peek(2'd2, "R1 hi", 8'h00);
    peek(2'd3, "R1 addr3", 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_direct();
    wr(2'd1, 8'h5A);
    wr(2'd2, 8'hC3);
    peek(2'd1, "R10 lo", 8'h5A);
    peek(2'd2, "R10 hi", 8'hC3);
  endtask

  task automatic t_hold();
    set_cnt(16'h0055);
    wr(2'd0, 8'h46);
    pulse(); pulse(); idle(20);
    peek(2'd1, "R6 hold lo", 8'h55);
    peek(2'd2, "R6 hold hi", 8'h00);
  endtask

  task automatic t_timer(logic [7:0] c, int ratio, int n, string req);
    wr(2'd0, C_OFF);
    set_cnt(16'h0000);
    wr(2'd0, c);
    idle(4 * ratio * n - 1);
    wr(2'd0, C_OFF);
    peek(2'd1, req, 8'(n));
  endtask

  task automatic t_sync();
    wr(2'd0, C_OFF);
    set_cnt(16'h0000);
    wr(2'd0, C_SYNC);
    ext = 1'b1;
    @(negedge clk); peek(2'd1, "R4 edge+1", 8'h00);
    @(negedge clk); peek(2'd1, "R4 edge+2", 8'h00);
    @(negedge clk); peek(2'd1, "R4 edge+3", 8'h01);
    ext = 1'b0; idle(3);
    pulse();
    peek(2'd1, "R4 two edges", 8'h02);
  endtask

  task automatic t_async();
    wr(2'd0, C_OFF);
    set_cnt(16'h0000);
    wr(2'd0, C_ASYNC);
    ext = 1'b1;
    @(negedge clk); peek(2'd1, "R5 edge+1", 8'h01);
    ext = 1'b0; idle(3);
    pulse();
    peek(2'd1, "R5 two edges", 8'h02);
  endtask

  task automatic t_sleep();
    wr(2'd0, C_OFF);
    set_cnt(16'h0000);
    sleep = 1'b1;
    wr(2'd0, C_TMR1); idle(40);
    peek(2'd1, "R9 timer asleep", 8'h00);
    wr(2'd0, C_SYNC); pulse(); pulse();
    peek(2'd1, "R9 sync asleep", 8'h00);
    wr(2'd0, C_ASYNC); pulse(); pulse();
    peek(2'd1, "R9 async asleep", 8'h02);
    wr(2'd0, C_OFF);
    sleep = 1'b0;
  endtask

  task automatic t_ext_presc();
    wr(2'd0, C_OFF);
    set_cnt(16'h0000);
    wr(2'd0, C_AS4);
    for (int i = 0; i < 8; i++) pulse();
    peek(2'd1, "R3 ext div4", 8'h02);
  endtask

  task automatic t_presc_restart();
    wr(2'd0, C_OFF);
    set_cnt(16'h0000);
    wr(2'd0, C_AS2);
    pulse();
    peek(2'd1, "R12 half", 8'h00);
    wr(2'd1, 8'h00);
    pulse();
    peek(2'd1, "R12 restarted", 8'h00);
    pulse();
    peek(2'd1, "R12 full", 8'h01);
  endtask

  task automatic t_overflow();
    wr(2'd0, C_OFF);
    set_cnt(16'hFFFF);
    wr(2'd0, C_ASYNC);
    check("R7 irq before", {7'd0, irq}, 8'h00);
    pulse();
    peek(2'd1, "R7 wrap lo", 8'h00);
    peek(2'd2, "R7 wrap hi", 8'h00);
    check("R7 irq set", {7'd0, irq}, 8'h01);
    pulse();
    wr(2'd0, C_ASYNC);
    check("R7 sticky", {7'd0, irq}, 8'h01);
    peek(2'd0, "R7 ctrl flag", 8'h47);
    wr(2'd0, 8'h07);
    check("R7 cleared", {7'd0, irq}, 8'h00);
    peek(2'd0, "R7 ctrl after clear", 8'h07);
    wr(2'd0, C_OFF);
  endtask

  task automatic t_clear();
    wr(2'd0, C_OFF);
    set_cnt(16'h1234);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    peek(2'd1, "R8 clr lo", 8'h00);
    peek(2'd2, "R8 clr hi", 8'h00);
    set_cnt(16'h1234);
    clr = 1'b1;
    wr(2'd1, 8'h77);
    clr = 1'b0;
    peek(2'd1, "R8 write wins lo", 8'h77);
    peek(2'd2, "R8 write wins hi", 8'h12);
  endtask

  task automatic t_wide();
    wr(2'd0, C_OFF);
    set_cnt(16'h3456);
    wr(2'd0, 8'h60);
    rd_lo("R11 lo read", 8'h56);
    peek(2'd2, "R11 buffered hi", 8'h34);
    wr(2'd2, 8'hAB);
    wr(2'd0, C_OFF);
    peek(2'd2, "R11 hi write buffered only", 8'h34);
    wr(2'd0, 8'h60);
    wr(2'd2, 8'hAB);
    wr(2'd1, 8'hCD);
    wr(2'd0, C_OFF);
    peek(2'd2, "R11 pair write hi", 8'hAB);
    peek(2'd1, "R11 pair write lo", 8'hCD);
    set_cnt(16'h12FF);
    wr(2'd0, 8'h67);
    rd_lo("R11 snap lo", 8'hFF);
    pulse();
    peek(2'd2, "R11 snap hi held", 8'h12);
    rd_lo("R11 new lo", 8'h00);
    peek(2'd2, "R11 new hi", 8'h13);
    wr(2'd0, C_OFF);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_direct();
    t_hold();
    t_timer(C_TMR1, 1, 5, "R2 timer div1");
    t_timer(C_TMR2, 2, 3, "R3 timer div2");
    t_timer(C_TMR8, 8, 2, "R3 timer div8");
    t_sync();
    t_async();
    t_sleep();
    t_ext_presc();
    t_presc_restart();
    t_overflow();
    t_clear();
    t_wide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule